// File: doc/BRIEF.md
# Two-Stage Baseline and Offset Calibration Sequencer

This block is the digital controller of a sensor front end that first pulls a sensor's baseline level to mid-rail and then trims the remaining small differential offset. After reset it produces two non-overlapping clock phases and runs a coarse search. An 8-bit code counts upward until a comparator shows that the level-shifted sensor signal has dropped to mid-rail. The upper six bits of that code select one tap of a resistor DAC through a one-hot vector. The lower two bits set how many of four interpolation capacitors are charged to the upper tap level instead of the tap below it.

After the coarse search, a second search steps a separate 6-bit trim code. It stops when a balance comparator reports that the differential output is balanced. Both codes are then frozen until the next reset. If either search runs to the top of its range without the comparator changing state, the code stays at full scale and a sticky out-of-range flag is set.

Comparators, DACs and capacitors sit outside the block. The block samples the comparators once per full two-phase period, which leaves the analog network time to settle between steps.

Top module: `cal_seq`

## Requirements
- R1: ph1 is high for PH_LEN clocks. Both phases are then low for DEAD clocks, ph2 is high for PH_LEN clocks, and both are low for DEAD clocks again. The full period is 2*(PH_LEN+DEAD) clocks, and ph1 and ph2 are never high together.
- R2: While rst_n is low, the outputs are: coarse_code = 0, fine_code = 0, done = 0, out_of_range = 0, tap_sel = 1 (tap 0), cap_hi = 0. ph1 is high.
- R3: tap_sel is always one-hot. Its set bit index equals the upper six bits (bits 7..2) of the live coarse code.
- R4: cap_hi bit i is 1 exactly when i is less than the lower two bits (bits 1..0) of the live coarse code, so 0 to 3 capacitors take the upper tap.
- R5: Comparators are sampled only on the last clock of each period, which follows the dead time after ph2. The first period after reset is an idle period. Each code changes at most once per period, and only by +1.
- R6: In the coarse search, the code increments at each sample while coarse_above is 1. At the first sample with coarse_above = 0, the code is held and placed on coarse_code, and the fine search begins.
- R7: In the fine search, fine_code increments at each sample while fine_unbal is 1. It stops at the first sample with fine_unbal = 0.
- R8: If the coarse code is 255 or the fine code is 63 at a sample where its comparator still asks for a step, the code stays there, out_of_range is set and stays set, and the sequence moves on.
- R9: With final codes c and f, done rises on clock edge (c+f+3)*2*(PH_LEN+DEAD) after reset release, counting the first edge after release as 1.
- R10: Once done is high, it stays high. coarse_code, fine_code, tap_sel and cap_hi stay unchanged whatever the comparators do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, restarts calibration |
| coarse_above | input | 1 | Shifted level above mid-rail |
| fine_unbal | input | 1 | Differential output not yet balanced |
| ph1 | output | 1 | Charge phase |
| ph2 | output | 1 | Share/amplify phase |
| tap_sel | output | 64 | One-hot resistor DAC tap select |
| cap_hi | output | 4 | Interpolation capacitors tied to the upper tap |
| coarse_code | output | 8 | Stored coarse code |
| fine_code | output | 6 | Fine trim code |
| done | output | 1 | Calibration finished, codes frozen |
| out_of_range | output | 1 | A search saturated at full scale |

## Verification
The bench builds the block with PH_LEN = 2 and DEAD = 1, which gives a 6-clock period. With that short period, full-scale runs of both searches (256 coarse and 64 fine samples) stay within a few thousand clocks. Many random baseline and offset targets can therefore be run, including targets beyond full scale that drive saturation. The code widths are left at 8 and 6 bits, so the real 64-tap one-hot decode and the 4-capacitor interpolation are both exercised over their whole range.

// File: rtl/cal_seq.sv
module cal_seq #(
  parameter int CW     = 8,
  parameter int IB     = 2,
  parameter int FW     = 6,
  parameter int PH_LEN = 4,
  parameter int DEAD   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    coarse_above,
  input  logic                    fine_unbal,
  output logic                    ph1,
  output logic                    ph2,
  output logic [(1<<(CW-IB))-1:0] tap_sel,
  output logic [(1<<IB)-1:0]      cap_hi,
  output logic [CW-1:0]           coarse_code,
  output logic [FW-1:0]           fine_code,
  output logic                    done,
  output logic                    out_of_range
);
  localparam int TAPS = 1 << (CW - IB);
  localparam int NCAP = 1 << IB;
  localparam int CYC  = 2 * (PH_LEN + DEAD);
  localparam int PW   = $clog2(CYC);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [FW-1:0] FMAX = '1;

  typedef enum logic [1:0] {IDLE, COARSE, FINE, HOLD} st_t;

  st_t           st;
  logic [PW-1:0] pcnt;
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (pcnt == PW'(CYC - 1));
  assign ph1  = (pcnt < PW'(PH_LEN));
  assign ph2  = (pcnt >= PW'(PH_LEN + DEAD)) && (pcnt < PW'(2 * PH_LEN + DEAD));
  assign done = (st == HOLD);

  assign tap_sel = {{(TAPS-1){1'b0}}, 1'b1} << cnt[CW-1:IB];

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    assign cap_hi[i] = (cnt[IB-1:0] > IB'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt         <= '0;
      st           <= IDLE;
      cnt          <= '0;
      coarse_code  <= '0;
      fine_code    <= '0;
      out_of_range <= 1'b0;
    end else begin
      pcnt <= tick ? '0 : pcnt + PW'(1);
      if (tick) begin
        case (st)
          IDLE: st <= COARSE;
          COARSE:
            if (coarse_above && cnt != CMAX) begin
              cnt         <= cnt + CW'(1);
              coarse_code <= cnt + CW'(1);
            end else begin
              coarse_code <= cnt;
              st          <= FINE;
              if (coarse_above) out_of_range <= 1'b1;
            end
          FINE:
            if (fine_unbal && fine_code != FMAX) begin
              fine_code <= fine_code + FW'(1);
            end else begin
              st <= HOLD;
              if (fine_unbal) out_of_range <= 1'b1;
            end
          default: ;
        endcase
      end
    end
  end

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ph1 && ph2));
  // R1
  dead_after_ph1_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ph1) |-> !ph2);
  // R1
  dead_after_ph2_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ph2) |-> !ph1);
  // R3
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(tap_sel) == 1);
  // R5
  step_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(cnt) && $stable(fine_code)));
  // R5
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + CW'(1)));
  // R8
  oor_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) out_of_range |=> out_of_range);
  // R10
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(coarse_code) && $stable(fine_code) && $stable(tap_sel)));
endmodule

// File: tb/cal_seq_test.sv
module cal_seq_test;
  localparam int PH_LEN = 2;
  localparam int DEAD   = 1;
  localparam int CYC    = 2 * (PH_LEN + DEAD);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        coarse_above, fine_unbal;
  logic        ph1, ph2, done, out_of_range;
  logic [63:0] tap_sel;
  logic [3:0]  cap_hi;
  logic [7:0]  coarse_code;
  logic [5:0]  fine_code;

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;
  int tgt_b = 0;
  int tgt_f = 0;
  bit freeze_cmp = 1'b0;
  bit rnd_a = 1'b0;
  bit rnd_u = 1'b0;

  always #2.5 clk = ~clk;

  cal_seq #(.CW(8), .IB(2), .FW(6), .PH_LEN(PH_LEN), .DEAD(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .coarse_above(coarse_above), .fine_unbal(fine_unbal),
    .ph1(ph1), .ph2(ph2), .tap_sel(tap_sel), .cap_hi(cap_hi),
    .coarse_code(coarse_code), .fine_code(fine_code), .done(done), .out_of_range(out_of_range)
  );

  function automatic int tap_idx(input logic [63:0] t);
    int r = -1;
    for (int i = 0; i < 64; i++) if (t[i]) r = i;
    return r;
  endfunction

  function automatic int ones4(input logic [3:0] v);
    int r = 0;
    for (int i = 0; i < 4; i++) if (v[i]) r++;
    return r;
  endfunction

  function automatic int live_code();
    return tap_idx(tap_sel) * 4 + ones4(cap_hi);
  endfunction

  function automatic int sat(input int v, input int m);
    return (v > m) ? m : v;
  endfunction

  function automatic logic [3:0] therm(input int n);
    logic [3:0] r = '0;
    for (int i = 0; i < 4; i++) r[i] = (i < n);
    return r;
  endfunction

  always_comb begin
    coarse_above = freeze_cmp ? rnd_a : (live_code() < tgt_b);
    fine_unbal   = freeze_cmp ? rnd_u : (int'(fine_code) < tgt_f);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1 phase monitor
  int  run1 = 0;
  int  gap = 0;
  bit  prev1 = 1'b0;
  bit  prev2 = 1'b0;
  bit  armed = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      run1 = 0; gap = 0; armed = 1'b0; prev1 = 1'b0; prev2 = 1'b0;
    end else begin
      chk(!(ph1 && ph2), "R1 overlap", int'(ph1 && ph2), 0);
      if (ph1) run1++;
      if (prev1 && !ph1) begin
        chk(run1 == PH_LEN, "R1 ph1 width", run1, PH_LEN);
        run1 = 0;
      end
      if (!ph1 && !ph2) gap++;
      else begin
        if (armed && !prev1 && !prev2) chk(gap == DEAD, "R1 dead time", gap, DEAD);
        gap = 0;
        armed = 1'b1;
      end
      prev1 = ph1; prev2 = ph2;
    end
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic trial(input int b, input int f);
    int ec, ef, n, expn;
    bit eo;
    logic [7:0] sc;
    logic [5:0] sf;
    ec = sat(b, 255);
    ef = sat(f, 63);
    eo = (b > 255) || (f > 63);
    expn = (ec + ef + 3) * CYC;
    tgt_b = b; tgt_f = f; freeze_cmp = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state
    chk(coarse_code == 0 && fine_code == 0, "R2 codes", int'(coarse_code) + int'(fine_code), 0);
    chk(!done && !out_of_range, "R2 flags", int'(done) + int'(out_of_range), 0);
    chk(tap_sel == 64'd1 && cap_hi == 4'd0 && ph1, "R2 dac", tap_idx(tap_sel), 0);
    rst_n = 1'b1;
    n = 0;
    while (n < 4000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      // R3 R4 live decode consistency
      chk(tap_idx(tap_sel) >= 0 && cap_hi[3] == 1'b0 && cap_hi == therm(ones4(cap_hi)),
          "R3 R4 decode", int'(cap_hi), int'(therm(ones4(cap_hi))));
      if (done) break;
    end
    // R9 done timing
    chk(n == expn, "R9 done edge", n, expn);
    // R6 coarse result and R8 saturation
    chk(int'(coarse_code) == ec, "R6 coarse code", coarse_code, ec);
    chk(live_code() == ec, "R3 R4 held dac code", live_code(), ec);
    chk(tap_sel == (64'd1 << (ec / 4)), "R3 tap bit", tap_idx(tap_sel), ec / 4);
    chk(cap_hi == therm(ec % 4), "R4 caps", int'(cap_hi), int'(therm(ec % 4)));
    // R7 fine result
    chk(int'(fine_code) == ef, "R7 fine code", fine_code, ef);
    chk(out_of_range == eo, "R8 out_of_range", out_of_range, eo);
    // R10 freeze with random comparators
    sc = coarse_code; sf = fine_code;
    freeze_cmp = 1'b1;
    for (int k = 0; k < 3 * CYC; k++) begin
      rnd_a = 1'($urandom); rnd_u = 1'($urandom);
      @(negedge clk);
    end
    chk(done && coarse_code == sc && fine_code == sf && live_code() == int'(sc),
        "R10 frozen", {coarse_code, fine_code}, {sc, sf});
    chk(out_of_range == eo, "R8 sticky", out_of_range, eo);
  endtask

  initial begin
    void'($urandom(32'd1234));
    coarse_code = coarse_code;
    // directed corners
    trial(0, 0);
    trial(1, 1);
    trial(255, 63);
    trial(256, 10);   // R8 coarse saturation
    trial(40, 64);    // R8 fine saturation
    trial(300, 90);
    trial(7, 0);
    // random
    for (int t = 0; t < 14; t++) trial(int'($urandom_range(0, 280)), int'($urandom_range(0, 70)));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule